// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight hardware interrupt lines into a single interrupt signal for a processor and tells the processor which line to serve. A rising edge on a line latches a pending request. Pending requests are filtered by a mask register. A priority resolver then picks the winner in fully nested order, so a request raises the interrupt output only when it outranks every level already in service.

The processor answers with two acknowledge pulses. The first pulse moves the winning request from the pending set into the in-service set. The second pulse presents an identifier byte, which is a vector base plus the level number. Software writes a command port to end service of a level, either the highest in-service level or a named one, and to rotate the priority order. It writes and reads the mask through a separate port.

All inputs are synchronous to `clk`. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset on the second clock edge after `rst_n` rises.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and after reset, the pending and in-service sets are empty, the mask reads FFh, `int_out` is low, `id_valid` is low, and level 0 ranks highest with level 7 lowest.
- R2: A write with `wr_sel`=1 loads `wr_data` into the mask, which appears on `mask_rd` from the next cycle. A 1 in bit n blocks level n and a 0 lets it through.
- R3: A request is latched only on a 0-to-1 transition of its line. A line held high produces no new request after its request has been granted.
- R4: `int_out` is high exactly when some unmasked pending level ranks strictly above every in-service level, or when there is such a level and nothing is in service.
- R5: On the first acknowledge pulse while `int_out` is high, the highest-ranked eligible level enters service and its pending bit clears.
- R6: On the second acknowledge pulse, `id_valid` is high for exactly the next cycle with `id_byte` = `VEC_BASE` (default 08h) + the level chosen at the first pulse.
- R7: If `int_out` is low at the first acknowledge pulse, no level enters service, and the identifier reports the level that currently ranks lowest.
- R8: A command write (`wr_sel`=0) with bits 7:5 = 001 clears the highest-ranked in-service level.
- R9: A command with bits 7:5 = 011 clears the in-service bit of the level given in bits 2:0.
- R10: A command with bits 7:5 = 110 makes the level in bits 2:0 the lowest-ranked. The next level above it, counting modulo 8, becomes the highest, and the rest follow in rising order.
- R11: A command with bits 7:5 = 010, a command with any other unlisted code, and a command with bits 4:3 not both 0 all leave every state unchanged.
- R12: A request on a masked line stays pending and asserts `int_out` once its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, edge-sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command port, 1 mask port |
| wr_data | input | 8 | Write data |
| mask_rd | output | 8 | Mask register readback |
| ack_pulse | input | 1 | Acknowledge pulse, one cycle per pulse |
| int_out | output | 1 | Interrupt request toward the processor |
| id_valid | output | 1 | Identifier byte valid, one cycle |
| id_byte | output | 8 | Interrupt identifier byte |

## Verification
Some properties are checked on every cycle: a granted first acknowledge adds exactly one in-service bit, a spurious one adds none, `int_out` never rises without an unmasked pending request, the identifier strobe lasts one cycle and follows a second acknowledge, and mask and priority writes land a cycle later. Other behaviour shows only in the bench's scenarios. These cover which level wins under masks and rotation, how nested blocking behaves as levels enter and leave service, which bit a non-specific EOI picks, that ignored commands change nothing, and that a line held high produces no second request.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVL_W = 3;
  localparam int N_LVL = 1 << LVL_W;

  typedef logic [N_LVL-1:0] lvl_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    OP_EOI_TOP  = 3'b001,
    OP_IDLE     = 3'b010,
    OP_EOI_LVL  = 3'b011,
    OP_ROTATE   = 3'b110
  } op_t;

  typedef struct packed {
    logic eoi_top;
    logic eoi_lvl;
    logic rotate;
    lvl_t lvl;
  } cmd_t;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = pic_pkg::N_LVL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign rise[g]   = lines[g] & ~prev_q[g];
    // a fresh edge wins over a grant clearing the same bit
    assign pend_d[g] = (pend_q[g] & ~clr[g]) | rise[g];
  end

  assign prev_d = lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N = pic_pkg::N_LVL,
  parameter int W = pic_pkg::LVL_W
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] hi_lvl,
  output logic         any,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rank
);
  // rank 0 is hi_lvl, rank N-1 is the level just below it
  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    rank = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (vec[(j + int'(hi_lvl)) % N]) begin
        any  = 1'b1;
        rank = W'(j);
        lvl  = W'((j + int'(hi_lvl)) % N);
      end
    end
  end
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_pkg::*;
(
  input  logic       wr_cmd,
  input  logic [7:0] data,
  output cmd_t       cmd
);
  logic valid;
  op_t  op;

  assign valid = wr_cmd && (data[4:3] == 2'b00);
  assign op    = op_t'(data[7:5]);

  always_comb begin
    cmd     = '0;
    cmd.lvl = data[LVL_W-1:0];
    if (valid) begin
      case (op)
        OP_EOI_TOP: cmd.eoi_top = 1'b1;
        OP_EOI_LVL: cmd.eoi_lvl = 1'b1;
        OP_ROTATE:  cmd.rotate  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int         ID_W     = 8,
  parameter logic [7:0] VEC_BASE = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  output logic [N_LVL-1:0] mask_rd,
  input  logic             ack_pulse,
  output logic             int_out,
  output logic             id_valid,
  output logic [ID_W-1:0]  id_byte
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  lvl_vec_t        mask_q, mask_d;
  lvl_vec_t        isr_q, isr_d;
  lvl_t            low_q, low_d;
  logic            phase_q, phase_d;
  lvl_t            sel_q, sel_d;
  logic            idv_q, idv_d;
  logic [ID_W-1:0] id_q, id_d;

  lvl_vec_t irr_q;
  lvl_vec_t grant_vec;
  lvl_vec_t eoi_clr;
  lvl_vec_t pend_ok;
  lvl_t     hi_lvl;
  logic     p_any, s_any;
  lvl_t     p_lvl, s_lvl, p_rank, s_rank;
  logic     eligible, ack_first, ack_second;
  cmd_t     cmd;

  pic_req_latch #(.N(N_LVL)) u_req (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lines (irq_in),
    .clr   (grant_vec),
    .pend  (irr_q)
  );

  assign hi_lvl  = low_q + 1'b1;
  assign pend_ok = irr_q & ~mask_q;

  pic_prio_resolve #(.N(N_LVL), .W(LVL_W)) u_res_pend (
    .vec    (pend_ok),
    .hi_lvl (hi_lvl),
    .any    (p_any),
    .lvl    (p_lvl),
    .rank   (p_rank)
  );

  pic_prio_resolve #(.N(N_LVL), .W(LVL_W)) u_res_svc (
    .vec    (isr_q),
    .hi_lvl (hi_lvl),
    .any    (s_any),
    .lvl    (s_lvl),
    .rank   (s_rank)
  );

  pic_cmd_decode u_dec (
    .wr_cmd (wr_en && !wr_sel),
    .data   (wr_data),
    .cmd    (cmd)
  );

  assign eligible   = p_any && (!s_any || (p_rank < s_rank));
  assign ack_first  = ack_pulse && !phase_q;
  assign ack_second = ack_pulse && phase_q;

  always_comb begin
    grant_vec = '0;
    if (ack_first && eligible) grant_vec = lvl_vec_t'(1) << p_lvl;

    eoi_clr = '0;
    if (cmd.eoi_top && s_any) eoi_clr = lvl_vec_t'(1) << s_lvl;
    if (cmd.eoi_lvl)          eoi_clr = lvl_vec_t'(1) << cmd.lvl;

    isr_d   = (isr_q & ~eoi_clr) | grant_vec;
    mask_d  = (wr_en && wr_sel) ? wr_data[N_LVL-1:0] : mask_q;
    low_d   = cmd.rotate ? cmd.lvl : low_q;
    phase_d = ack_pulse ? !phase_q : phase_q;
    sel_d   = sel_q;
    if (ack_first) sel_d = eligible ? p_lvl : low_q;
    idv_d   = ack_second;
    id_d    = ack_second ? (VEC_BASE + ID_W'(sel_q)) : id_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q  <= '1;
      isr_q   <= '0;
      low_q   <= lvl_t'(N_LVL - 1);
      phase_q <= 1'b0;
      sel_q   <= '0;
      idv_q   <= 1'b0;
      id_q    <= '0;
    end else begin
      mask_q  <= mask_d;
      isr_q   <= isr_d;
      low_q   <= low_d;
      phase_q <= phase_d;
      sel_q   <= sel_d;
      idv_q   <= idv_d;
      id_q    <= id_d;
    end
  end

  assign mask_rd  = mask_q;
  assign int_out  = eligible;
  assign id_valid = idv_q;
  assign id_byte  = id_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N = 8,
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irr,
  input logic [N-1:0] mask,
  input logic [N-1:0] isr,
  input logic [W-1:0] low,
  input logic         phase,
  input logic         ack_pulse,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [7:0]   wr_data,
  input logic [N-1:0] mask_rd,
  input logic         int_out,
  input logic         id_valid
);
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mask_rd == $past(wr_data[N-1:0])));

  p_int_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  p_grant_adds_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !phase && int_out && !wr_en)
      |=> ($countones(isr) == $past($countones(isr)) + 1));

  p_id_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  p_id_after_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_valid) |-> $past(ack_pulse && phase));

  p_spurious_keeps_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !phase && !int_out && !wr_en) |=> (isr == $past(isr)));

  p_rotate_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[7:5] == 3'b110 && wr_data[4:3] == 2'b00)
      |=> (low == $past(wr_data[W-1:0])));
endmodule

bind prio_irq_ctrl pic_checker #(.N(pic_pkg::N_LVL), .W(pic_pkg::LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .irr       (irr_q),
  .mask      (mask_q),
  .isr       (isr_q),
  .low       (low_q),
  .phase     (phase_q),
  .ack_pulse (ack_pulse),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .mask_rd   (mask_rd),
  .int_out   (int_out),
  .id_valid  (id_valid)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       wr_en, wr_sel, ack_pulse;
  logic [7:0] wr_data;
  logic [7:0] mask_rd, id_byte;
  logic       int_out, id_valid;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .mask_rd   (mask_rd),
    .ack_pulse (ack_pulse),
    .int_out   (int_out),
    .id_valid  (id_valid),
    .id_byte   (id_byte)
  );

  // {mask, lines raised, expected int_out, expected id_byte}
  localparam logic [31:0] VECS [6] = '{
    {8'h00, 8'h30, 8'h01, 8'h0C},
    {8'h10, 8'h30, 8'h01, 8'h0D},
    {8'hFF, 8'h81, 8'h00, 8'h0F},
    {8'h00, 8'h80, 8'h01, 8'h0F},
    {8'h00, 8'h01, 8'h01, 8'h08},
    {8'h01, 8'h03, 8'h01, 8'h09}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_data = '0; ack_pulse = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic raise(input logic [7:0] l);
    irq_in = irq_in | l;
    step();
  endtask

  task automatic ack_pair(input string req, input logic [7:0] exp_id);
    ack_pulse = 1'b1; step();
    ack_pulse = 1'b0; step();
    ack_pulse = 1'b1; step();
    ack_pulse = 1'b0;
    chk({req, " id_valid"}, 8'(id_valid), 8'h01);
    chk({req, " id_byte"}, id_byte, exp_id);
    step();
    chk({req, " id_valid drop"}, 8'(id_valid), 8'h00);
  endtask

  initial begin
    #2000000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 int_out", 8'(int_out), 8'h00);
    chk("R1 mask", mask_rd, 8'hFF);
    chk("R1 id_valid", 8'(id_valid), 8'h00);

    // table walk: R4 R5 R6 R7 with default order, mask R2
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(1'b1, VECS[i][31:24]);
      chk("R2 mask readback", mask_rd, VECS[i][31:24]);
      raise(VECS[i][23:16]);
      chk("R4 int_out", 8'(int_out), VECS[i][15:8]);
      ack_pair("R6/R7", VECS[i][7:0]);
      if (i == 2) begin
        // R12 masked request still pending
        wr(1'b1, 8'h7F);
        chk("R12 int after unmask", 8'(int_out), 8'h01);
        ack_pair("R12", 8'h0F);
      end
    end

    // nesting, EOI kinds, ignored commands
    do_reset();
    wr(1'b1, 8'h00);
    raise(8'h08);
    chk("R4 int lvl3", 8'(int_out), 8'h01);
    ack_pair("R5", 8'h0B);
    chk("R5 pending cleared", 8'(int_out), 8'h00);
    raise(8'h20);
    chk("R4 lower blocked", 8'(int_out), 8'h00);
    raise(8'h02);
    chk("R4 higher passes", 8'(int_out), 8'h01);
    ack_pair("R5 nested", 8'h09);
    wr(1'b0, 8'h20);
    chk("R8 top EOI clears lvl1 only", 8'(int_out), 8'h00);
    wr(1'b0, 8'h28);
    chk("R11 bits4:3 ignored", 8'(int_out), 8'h00);
    wr(1'b0, 8'h40);
    chk("R11 nop", 8'(int_out), 8'h00);
    wr(1'b0, 8'hE3);
    chk("R11 unlisted code", 8'(int_out), 8'h00);
    wr(1'b0, 8'h63);
    chk("R9 specific EOI lvl3", 8'(int_out), 8'h01);
    ack_pair("R9", 8'h0D);
    wr(1'b0, 8'h65);
    chk("R3 held lines no rerequest", 8'(int_out), 8'h00);
    irq_in = '0; step();
    raise(8'h08);
    chk("R3 new edge", 8'(int_out), 8'h01);
    ack_pair("R3", 8'h0B);
    wr(1'b0, 8'h63);

    // rotation
    do_reset();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hC2);
    raise(8'h25);
    ack_pair("R10 first", 8'h0D);
    wr(1'b0, 8'h20);
    ack_pair("R10 second", 8'h08);
    chk("R10 lvl2 below lvl0", 8'(int_out), 8'h00);
    wr(1'b0, 8'h20);
    chk("R10 lvl2 after EOI", 8'(int_out), 8'h01);
    ack_pair("R10 third", 8'h0A);
    wr(1'b0, 8'h20);
    ack_pair("R7 rotated spurious", 8'h0A);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule